// File: doc/BRIEF.md
# FIFO Burst Capture Reader

This block pulls a burst of a fixed number of words from the read side of an external first-word-fall-through FIFO and keeps them in a small internal buffer. It sees the FIFO through three signals: the head word, an empty flag and a read strobe. The strobe pops the head word in the same cycle it is high. Control uses a start pulse, an idle level and a one-cycle done pulse that comes with a return value. A processor-side port then reads the captured words back by index.

A mode input is sampled together with start. In blocking mode the block waits on the current slot for as long as the FIFO is empty, so a capture always ends with every slot filled. In non-blocking mode the capture takes exactly one cycle per slot. A slot whose cycle saw an empty FIFO stays unfilled, and a per-slot valid flag plus a count of captured words show which slots hold data.

Top module: `fifo_burst_reader`

## Requirements
- R1: While rst_ni is low, idle_o is 1 and fifo_rd_en_o, done_o, ret_o and valid_cnt_o are 0. This also holds when reset is asserted in the middle of a capture.
- R2: fifo_rd_en_o is high only in a cycle where a capture is running and fifo_empty_i is low.
- R3: The k-th word popped during a capture is stored in slot k-1, counting upward from slot 0. In non-blocking mode a word popped in capture cycle c is stored in slot c.
- R4: In blocking mode, when the FIFO never reports empty during the capture, fifo_rd_en_o is high for exactly N_WORDS consecutive cycles. done_o then rises in the cycle after the last pop.
- R5: In blocking mode, a cycle with fifo_empty_i high pops nothing and does not advance the slot index. The capture ends only after N_WORDS pops.
- R6: In non-blocking mode the capture lasts exactly N_WORDS cycles whatever the empty flag does, and done_o is seen N_WORDS cycles after the start edge.
- R7: Each slot's valid flag (rd_valid_o) is cleared when a capture starts. It is set to 1 only when a word is stored into that slot.
- R8: At done, valid_cnt_o equals the number of words popped in that capture. This is N_WORDS in blocking mode.
- R9: done_o is a single-cycle pulse. ret_o is 1 in the done cycle and 0 at all other times.
- R10: fifo_rd_en_o is low in the done cycle and stays low until the next accepted start.
- R11: A start_i received while a capture is running is ignored. It neither restarts the slot index nor changes the mode.
- R12: A read request on rd_req_i with index rd_idx_i returns that slot's word and valid flag on rd_data_o and rd_valid_o one cycle later. When the request falls in the same cycle as the capture writing that slot, the value from before the write is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| nonblock_i | input | 1 | Mode sampled at start: 1 non-blocking, 0 blocking |
| idle_o | output | 1 | High when no capture is running |
| done_o | output | 1 | One-cycle completion pulse |
| ret_o | output | DATA_W | Return value, 1 with done_o, otherwise 0 |
| valid_cnt_o | output | CNT_W | Number of words captured in the last capture |
| fifo_data_i | input | DATA_W | FIFO head word |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_rd_en_o | output | 1 | FIFO pop strobe |
| rd_req_i | input | 1 | Buffer read request |
| rd_idx_i | input | IDX_W | Buffer slot index to read |
| rd_data_o | output | DATA_W | Word read from the buffer |
| rd_valid_o | output | 1 | Valid flag of the slot read |

## Verification
The buffer read port and the capture write can address the same slot in the same cycle. The bench provokes this during a non-blocking capture over a buffer that already holds known words from an earlier burst. It requests slot 3 in the very cycle that slot 3 is being refilled, and expects the old word with a cleared valid flag. It then requests slot 2, which was written one cycle earlier, and expects the new word with its flag set. A read after done confirms that slot 3 holds the new word. A second overlap is a start pulse that lands during a stalled blocking capture while asking for non-blocking mode. It is judged by the capture length and by the order of the stored words.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fbr_state_e;
endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int N_WORDS = 10,
  parameter int IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             nonblock_i,
  input  logic             fifo_empty_i,
  output logic             busy_o,
  output logic             take_o,
  output logic             clear_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  fbr_state_e       state_q;
  logic             nb_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             busy, take, advance, last, finish;

  assign busy    = (state_q == ST_BUSY);
  assign take    = busy & ~fifo_empty_i;
  // non-blocking steps every cycle, blocking only on a pop
  assign advance = busy & (nb_q | take);
  assign last    = (idx_q == LAST_IDX);
  assign finish  = advance & last;
  assign clear_o = ~busy & start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nb_q    <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (clear_o) begin
        state_q <= ST_BUSY;
        nb_q    <= nonblock_i;
        idx_q   <= '0;
      end else if (advance) begin
        idx_q <= last ? '0 : idx_q + IDX_W'(1);
        if (last) state_q <= ST_IDLE;
      end
    end
  end

  assign busy_o = busy;
  assign take_o = take;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  assert_nb_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && nb_q && !last) |=> (busy_o && idx_q == $past(idx_q) + IDX_W'(1)));
  assert_blk_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !nb_q && fifo_empty_i) |=> (busy_o && idx_q == $past(idx_q)));
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> (nb_q == $past(nb_q)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/fbr_buffer.sv
module fbr_buffer #(
  parameter int N_WORDS = 10,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_req_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] slot_q [N_WORDS];
  logic [N_WORDS-1:0] vld_q;
  logic [CNT_W-1:0]   cnt_q;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
    logic hit;
    assign hit = we_i && (widx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else begin
        if (hit) slot_q[g] <= wdata_i;
        if (clear_i)  vld_q[g] <= 1'b0;
        else if (hit) vld_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (we_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

  // registered read; an out-of-range index returns zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else if (rd_req_i) begin
      if (32'(rd_idx_i) < N_WORDS) begin
        rd_data_o  <= slot_q[rd_idx_i];
        rd_valid_o <= vld_q[rd_idx_i];
      end else begin
        rd_data_o  <= '0;
        rd_valid_o <= 1'b0;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= N_WORDS);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && vld_q == '0));
  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o) && $stable(rd_valid_o));
endmodule

// File: rtl/fifo_burst_reader.sv
module fifo_burst_reader #(
  parameter int N_WORDS = 10,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int CNT_W  = $clog2(N_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              nonblock_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] ret_o,
  output logic [CNT_W-1:0]  valid_cnt_o,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_rd_en_o,
  input  logic              rd_req_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic             busy, take, clear, done;
  logic [IDX_W-1:0] idx;

  fbr_ctrl #(
    .N_WORDS(N_WORDS),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .nonblock_i  (nonblock_i),
    .fifo_empty_i(fifo_empty_i),
    .busy_o      (busy),
    .take_o      (take),
    .clear_o     (clear),
    .idx_o       (idx),
    .done_o      (done)
  );

  fbr_buffer #(
    .N_WORDS(N_WORDS),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .we_i      (take),
    .widx_i    (idx),
    .wdata_i   (fifo_data_i),
    .rd_req_i  (rd_req_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o),
    .cnt_o     (valid_cnt_o)
  );

  assign idle_o       = ~busy;
  assign done_o       = done;
  assign fifo_rd_en_o = take;
  assign ret_o        = {{(DATA_W-1){1'b0}}, done};

  assert_empty_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_en_o |-> (!fifo_empty_i && !idle_o));
  assert_rd_en_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fifo_rd_en_o);
  assert_ret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ret_o == DATA_W'(1)));
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idle_o);
endmodule

// File: tb/fifo_burst_reader_test.sv
module fifo_burst_reader_test;
  localparam int N   = 10;
  localparam int DW  = 32;
  localparam int NV  = 6;
  localparam int V_NB   [NV] = '{0, 0, 1, 1, 1, 0};
  localparam int V_FILL [NV] = '{10, 12, 10, 4, 20, 10};
  localparam logic [31:0] V_MASK [NV] =
    '{32'h0, 32'hA6, 32'h0, 32'h2, 32'h155, 32'h3};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, nonblock_i = 1'b0;
  logic          idle_o, done_o, fifo_rd_en_o, rd_valid_o;
  logic [DW-1:0] ret_o, fifo_data_i, rd_data_o;
  logic [3:0]    valid_cnt_o;
  logic          fifo_empty_i;
  logic          rd_req_i = 1'b0;
  logic [3:0]    rd_idx_i = '0;

  logic [31:0] fmem [256];
  logic [7:0]  fhead = '0, ftail = '0;
  logic        flush = 1'b0;
  logic [31:0] cmask = '0;
  int          bcyc = 0;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  fifo_burst_reader #(.N_WORDS(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .nonblock_i(nonblock_i),
    .idle_o(idle_o), .done_o(done_o), .ret_o(ret_o), .valid_cnt_o(valid_cnt_o),
    .fifo_data_i(fifo_data_i), .fifo_empty_i(fifo_empty_i),
    .fifo_rd_en_o(fifo_rd_en_o), .rd_req_i(rd_req_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  // first-word-fall-through FIFO model with per-capture-cycle empty gating
  assign fifo_data_i  = fmem[fhead];
  assign fifo_empty_i = (fhead == ftail) || (!idle_o && bcyc < 32 && cmask[bcyc]);

  always @(posedge clk) begin
    if (flush)             fhead <= ftail;
    else if (fifo_rd_en_o) fhead <= fhead + 8'd1;
    bcyc <= idle_o ? 0 : bcyc + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int cnt, input logic [31:0] base);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int j = 0; j < cnt; j++) begin
      fmem[ftail] = base + 32'(j);
      ftail = ftail + 8'd1;
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] d, output logic v);
    @(negedge clk); rd_req_i = 1'b1; rd_idx_i = 4'(idx);
    @(negedge clk); rd_req_i = 1'b0; d = rd_data_o; v = rd_valid_o;
  endtask

  task automatic run_case(input int nb, input int fill, input logic [31:0] mask,
                          input logic [31:0] base, input int poke, input string tag);
    logic [31:0] ev [N];
    logic        ek [N];
    int avail, nxt, slot, c, pops, dcyc;
    logic [31:0] d;
    logic v;
    // expected model
    avail = fill; nxt = 0; slot = 0; c = 0;
    for (int i = 0; i < N; i++) begin ev[i] = '0; ek[i] = 1'b0; end
    while ((nb != 0) ? (c < N) : (slot < N && c < 200)) begin
      if (!(avail == 0 || (c < 32 && mask[c]))) begin
        if (nb != 0) begin ev[c] = base + 32'(nxt); ek[c] = 1'b1; end
        else begin ev[slot] = base + 32'(nxt); ek[slot] = 1'b1; slot++; end
        nxt++; avail--;
      end
      c++;
    end
    load(fill, base);
    cmask = mask;
    @(negedge clk); start_i = 1'b1; nonblock_i = (nb != 0);
    @(negedge clk);
    pops = 0; dcyc = -1;
    for (int k = 0; k < 300; k++) begin
      start_i = (k == poke); nonblock_i = (k == poke);
      if (fifo_rd_en_o) pops++;
      @(negedge clk);
      if (done_o) begin dcyc = k + 1; break; end
    end
    start_i = 1'b0; nonblock_i = 1'b0;
    chk({tag, " R4/R5/R6 capture length"}, 32'(dcyc), 32'(c));
    chk({tag, " R4 pops"}, 32'(pops), 32'(nxt));
    chk({tag, " R9 ret at done"}, ret_o, 32'd1);
    chk({tag, " R8 valid count"}, 32'(valid_cnt_o), 32'(nxt));
    chk({tag, " R10 rd_en low at done"}, 32'(fifo_rd_en_o), 32'd0);
    @(negedge clk);
    chk({tag, " R9 done pulse"}, {30'd0, done_o, ret_o[0]}, 32'd0);
    chk({tag, " R10 idle after"}, {30'd0, idle_o, fifo_rd_en_o}, 32'd2);
    for (int i = 0; i < N; i++) begin
      rd(i, d, v);
      chk({tag, " R7 slot valid"}, 32'(v), 32'(ek[i]));
      if (ek[i]) chk({tag, " R3 slot data"}, d, ev[i]);
    end
    cmask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    // R1 reset state
    #12;
    chk("R1 idle in reset", {31'd0, idle_o}, 32'd1);
    chk("R1 outputs in reset", {29'd0, fifo_rd_en_o, done_o, |ret_o}, 32'd0);
    chk("R1 count in reset", 32'(valid_cnt_o), 32'd0);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      run_case(V_NB[i], V_FILL[i], V_MASK[i], 32'h100 * 32'(i + 1), -1,
               $sformatf("vec%0d", i));

    // R11: start asking for non-blocking mode while a blocking capture stalls
    run_case(0, 10, 32'h1F, 32'h900, 2, "R11 restart");

    // R12: read collides with the write of the same slot
    run_case(1, 10, 32'h0, 32'h500, -1, "R12 prefill");
    load(10, 32'h600);
    @(negedge clk); start_i = 1'b1; nonblock_i = 1'b1;
    @(negedge clk); start_i = 1'b0; nonblock_i = 1'b0;
    for (int k = 0; k < N + 2; k++) begin
      if (k == 4) begin
        chk("R12 collision old data", rd_data_o, 32'h503);
        chk("R12 collision old valid", 32'(rd_valid_o), 32'd0);
      end
      if (k == 5) begin
        chk("R12 written slot data", rd_data_o, 32'h602);
        chk("R12 written slot valid", 32'(rd_valid_o), 32'd1);
      end
      if (k == 3)      begin rd_req_i = 1'b1; rd_idx_i = 4'd3; end
      else if (k == 4) rd_idx_i = 4'd2;
      else             rd_req_i = 1'b0;
      @(negedge clk);
    end
    rd(3, d, v);
    chk("R12 slot after capture", d, 32'h603);

    // R1: asynchronous reset in the middle of a stalled capture
    load(3, 32'hA00);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 stalled capture busy", {31'd0, idle_o}, 32'd0);
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-capture reset idle", {30'd0, idle_o, fifo_rd_en_o}, 32'd2);
    chk("R1 mid-capture reset count", 32'(valid_cnt_o), 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    load(0, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule